// File: doc/BRIEF.md
# Switch-Selectable Multi-Rate LED Blinker

This block drives a single LED from one system clock. The LED blinks at one of four fixed rates, and the on-time and off-time of each period are equal. There is one divider per rate. All four dividers count and toggle at all times, whether or not their rate is selected. A purely combinational four-way selector, steered by a two-bit switch value, picks one divider's square wave. An enable switch then gates that wave before it reaches the LED pin.

All frequencies are parameters. By default the clock is 25 MHz and the rates are 100 Hz, 50 Hz, 10 Hz and 1 Hz. The number of clocks between toggles for each rate is the clock frequency divided by twice that rate. A simulation can therefore use a small clock frequency and still see every rate wrap within a few thousand cycles. Switch debouncing, clock generation and pad drive strength are handled outside the block.

Top module: `multi_rate_blinker`

## Requirements
- R1: For each rate k, the half-period length H_k equals CLK_HZ / (2 * rate_k) clocks. The defaults are CLK_HZ = 25 MHz and rates 100, 50, 10 and 1 Hz, which give H = 125000 for 100 Hz.
- R2: Each divider counts from 0 up to H_k-1. On the edge where its count equals H_k-1, it returns the count to 0 and inverts its square wave. After reset release, the first inversion lands on the H_k-th rising edge.
- R3: The select encoding on `rate_sel` is 2'b00 for rate 0 (100 Hz), 2'b01 for rate 1 (50 Hz), 2'b10 for rate 2 (10 Hz) and 2'b11 for rate 3 (1 Hz).
- R4: When `led_en` is 0, `led` is 0 whatever the select value and the divider states are.
- R5: When `led_en` is 1, `led` equals the selected divider's square wave. A change on `rate_sel` or `led_en` reaches `led` in the same cycle, with no register in the path.
- R6: Every divider keeps running while it is not selected. After a change of selection, the newly selected wave shows the phase it would have had if it had been selected since reset.
- R7: A synchronous active-low reset (`rst_n` = 0 at a rising edge) clears every counter and every square wave to 0, so `led` is 0 after such an edge.
- R8: Each selected wave is high for exactly H_k cycles and then low for exactly H_k cycles, which gives a 50% duty cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| led_en | input | 1 | Enable switch; 0 forces the LED off |
| rate_sel | input | 2 | Rate select switches (encoding in R3) |
| led | output | 1 | LED drive |

## Verification
Two events can fall in the same cycle: a change of switch setting and a divider toggling at its wrap. They meet whenever `rate_sel` or `led_en` moves in a cycle where the old or new divider has just inverted. The bench provokes this by walking the select value on every cycle, while flipping the enable every few cycles, across the wrap points of the fast dividers. Each cycle is judged against a reference that computes every divider's phase from the edges elapsed since reset. The check requires `led` to show the newly selected phase in that same cycle, with no lag and no restart of the divider.

// File: rtl/blink_pkg.sv
// Package: shared types and helpers for the multi-rate blinker.
// Assumes every rate is at most CLK_HZ/2, so each half-period is at least 1.
package blink_pkg;

    localparam int unsigned NUM_RATES = 4;
    localparam int unsigned SEL_W     = $clog2(NUM_RATES);

    // Select codes; the order is the behaviour (R3).
    typedef enum logic [SEL_W-1:0] {
        RATE_FAST   = 2'b00,
        RATE_MID    = 2'b01,
        RATE_SLOW   = 2'b10,
        RATE_SLOWER = 2'b11
    } rate_sel_e;

    // Clocks between toggles for one rate: clk / (2 * rate), floor 1 (R1).
    function automatic int unsigned half_period(input int unsigned clk_hz,
                                                input int unsigned rate_hz);
        int unsigned h;
        h = clk_hz / (2 * rate_hz);
        return (h == 0) ? 1 : h;
    endfunction

    // Counter width able to hold values 0 .. half-1, minimum one bit.
    function automatic int unsigned count_width(input int unsigned half);
        return (half > 1) ? $clog2(half) : 1;
    endfunction

endpackage

// File: rtl/blink_toggle_gen.sv
// Module: one free-running square-wave divider.
// Counts 0..HALF-1. On the HALF-1 edge it wraps to 0 and inverts the wave.
// It runs at all times, with no enable (R6).
// Assumes HALF >= 1 and a synchronous active-low reset.
module blink_toggle_gen #(
    parameter int unsigned HALF = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic wave
);
    import blink_pkg::*;

    localparam int unsigned CW = count_width(HALF);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          wave_q;
    logic          at_last;

    assign at_last = (cnt_q == LAST);

    // Purpose: advance the half-period counter and wrap it at the last count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (at_last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: invert the square wave in the cycle where the counter wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave_q <= 1'b0;
        end else if (at_last) begin
            wave_q <= ~wave_q;
        end
    end

    assign wave = wave_q;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R2

    AST_FLIP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        at_last |=> (wave_q != $past(wave_q)) && (cnt_q == '0)); // R2

    AST_HOLD_MID_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        !at_last |=> $stable(wave_q)); // R8

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0) && !wave_q); // R7

endmodule

// File: rtl/blink_rate_mux.sv
// Module: combinational four-way wave selector followed by the enable gate.
// No clock is involved, so a switch change shows on the output in the same cycle (R5).
// Assumes the waves are indexed by the select code of R3.
module blink_rate_mux #(
    parameter int unsigned N     = 4,
    parameter int unsigned SEL_W = 2
) (
    input  logic [N-1:0]     waves,
    input  logic [SEL_W-1:0] sel,
    input  logic             enable,
    output logic             out
);
    logic picked;

    // Purpose: pass the wave chosen by sel, or 0 for an index out of range.
    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (sel == SEL_W'(i)) begin
                picked = waves[i];
            end
        end
    end

    // Purpose: force the output low while the enable switch is off (R4).
    always_comb begin
        out = enable & picked;
    end

    always_comb begin
        AST_GATE_OFF: assert (enable || !out); // R4
    end

endmodule

// File: rtl/multi_rate_blinker.sv
// Module: top of the multi-rate LED blinker.
// Four dividers run in parallel. A combinational selector and the enable gate drive the LED.
// Assumes the switches are already synchronous and debounced,
// and that every rate is at most CLK_HZ/2.
module multi_rate_blinker #(
    parameter int unsigned CLK_HZ   = 25_000_000,
    parameter int unsigned RATE0_HZ = 100,
    parameter int unsigned RATE1_HZ = 50,
    parameter int unsigned RATE2_HZ = 10,
    parameter int unsigned RATE3_HZ = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       led_en,
    input  logic [1:0] rate_sel,
    output logic       led
);
    import blink_pkg::*;

    localparam int unsigned RATES [NUM_RATES] = '{RATE0_HZ, RATE1_HZ, RATE2_HZ, RATE3_HZ};

    logic [NUM_RATES-1:0] waves;

    // One divider per rate; all run concurrently (R6).
    for (genvar k = 0; k < NUM_RATES; k++) begin : g_rate
        localparam int unsigned HALF_K = half_period(CLK_HZ, RATES[k]);

        blink_toggle_gen #(
            .HALF (HALF_K)
        ) u_gen (
            .clk   (clk),
            .rst_n (rst_n),
            .wave  (waves[k])
        );
    end

    blink_rate_mux #(
        .N     (NUM_RATES),
        .SEL_W (SEL_W)
    ) u_mux (
        .waves  (waves),
        .sel    (rate_sel),
        .enable (led_en),
        .out    (led)
    );

    AST_LED_TRACKS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        led_en |-> (led == waves[rate_sel])); // R5

    AST_LED_DARK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !led_en |-> !led); // R4

    AST_LED_DARK_RESET: assert property (@(posedge clk)
        !rst_n |=> !led); // R7

endmodule

// File: tb/multi_rate_blinker_tb_top.sv
// Scoreboard bench. The driver task sets the switches at each falling edge and pushes
// the LED value that the requirements predict. The monitor pops that value and
// compares it with the LED shortly after. The scaled clock gives H = 10, 20, 100, 1000 (R1).
module multi_rate_blinker_tb_top;

    localparam int unsigned TB_CLK_HZ = 2000;
    localparam int unsigned R_HZ [4] = '{100, 50, 10, 1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       led_en = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic       led;

    typedef struct {
        logic  exp;
        string tag;
        int    n;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    fails  = 0;
    int    n_edges = 0;      // rising edges since last reset edge
    bit    state_known = 0;
    bit    last_was_reset = 1;
    logic [1:0] prev_sel = 2'b00;
    bit    done = 0;

    always #5 clk = ~clk;

    multi_rate_blinker #(
        .CLK_HZ   (TB_CLK_HZ),
        .RATE0_HZ (R_HZ[0]),
        .RATE1_HZ (R_HZ[1]),
        .RATE2_HZ (R_HZ[2]),
        .RATE3_HZ (R_HZ[3])
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .led_en   (led_en),
        .rate_sel (rate_sel),
        .led      (led)
    );

    // Reference phase from the requirements: toggles every H edges (R2, R8).
    function automatic logic ref_wave(input int k, input int n);
        int h;
        h = TB_CLK_HZ / (2 * R_HZ[k]);
        return logic'((n / h) % 2);
    endfunction

    // Driver: one cycle of stimulus, plus the expected LED value for that cycle.
    task automatic cycle(input logic [1:0] s, input logic e, input logic r);
        item_t it;
        @(negedge clk);
        rate_sel = s;
        led_en   = e;
        rst_n    = r;
        if (state_known) begin
            it.n   = n_edges;
            it.exp = e & ref_wave(int'(s), n_edges);
            if (!e)                  it.tag = "R4";
            else if (last_was_reset) it.tag = "R7";
            else if (s != prev_sel)  it.tag = "R5/R6";
            else                     it.tag = "R2/R3/R8";
            q.push_back(it);
        end
        prev_sel = s;
        @(posedge clk);
        state_known = 1;
        if (!r) begin
            n_edges = 0;
            last_was_reset = 1;
        end else begin
            n_edges++;
            last_was_reset = 0;
        end
    endtask

    task automatic run(input logic [1:0] s, input logic e, input int cycles);
        for (int i = 0; i < cycles; i++) cycle(s, e, 1'b1);
    endtask

    // Monitor: compare each expected item with the LED.
    always @(negedge clk) begin
        #1;
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (led !== it.exp) begin
                fails++;
                $display("FAIL %s at edge %0d: led=%b expected=%b", it.tag, it.n, led, it.exp);
            end
        end
    end

    initial begin
        // R7: LED stays dark while reset is held, even with enable on.
        for (int i = 0; i < 3; i++) cycle(2'b00, 1'b1, 1'b0);
        // R2/R3: 100 Hz code, wraps every 10 edges.
        run(2'b00, 1'b1, 50);
        // R3/R6: 50 Hz code selected mid-run keeps its running phase.
        run(2'b01, 1'b1, 50);
        // R4: enable off hides the wave.
        run(2'b10, 1'b0, 30);
        // R3/R8: 10 Hz code.
        run(2'b10, 1'b1, 100);
        // R3/R8: 1 Hz code; first wrap after 1000 edges in total.
        run(2'b11, 1'b1, 1100);
        // R5/R6: switch changes in the same cycle as divider wraps.
        for (int i = 0; i < 60; i++) cycle(2'(i % 4), logic'((i / 3) % 2 == 0), 1'b1);
        // R7: reset in the middle of a run, then restart.
        for (int i = 0; i < 2; i++) cycle(2'b01, 1'b1, 1'b0);
        run(2'b00, 1'b1, 25);
        run(2'b01, 1'b1, 25);
        @(negedge clk);
        #2;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule